// File: doc/BRIEF.md
# Register Rename Map with Free List

This block renames one instruction per clock for an out-of-order core. Each architectural register number an instruction names, as a source or as a destination, is looked up in a remap table that returns a physical tag and a ready bit. An instruction that writes a destination is given a fresh tag from a FIFO of free tags. The new tag is installed as the mapping for that register and is marked busy. The tag it displaces is kept, together with the instruction, in a program-order history queue.

Result broadcasts from execution mark every mapping that holds the broadcast tag as ready. A graduation event retires the oldest queued instruction and hands its displaced tag back to the free FIFO. On a misprediction or exception the caller gives the sequence number of the last instruction to keep. The block then unwinds the younger entries one per clock, youngest first. For each one it puts the saved tag back into the table and returns the tag that entry had taken to the free FIFO. Rename is held off until the unwind is complete.

Top module: `reg_rename_map`

## Requirements
- R1: After reset, architectural register i maps to physical tag i and is ready. The free FIFO holds tags NUM_ARCH to NUM_PHYS-1, and tag NUM_ARCH is at its head.
- R2: Both source lookups show, in the same cycle, the current mapping tag and ready bit of the named register. An instruction's sources see the mapping as it was before its own destination write.
- R3: An accepted instruction with a destination receives the head of the free FIFO on `dst_tag`. From the next cycle, that register maps to the new tag and reads as not ready.
- R4: A result broadcast makes every table entry that holds the broadcast tag ready from the next cycle on.
- R5: A source whose looked-up tag equals a tag broadcast in the same cycle is reported as ready in that cycle.
- R6: Graduation pops the oldest queued instruction. If it had a destination, its displaced tag goes to the tail of the free FIFO, and tags are handed out again in the order they were returned.
- R7: `ren_stall` is 1 while the free FIFO is empty. A stalled instruction takes no tag and changes no mapping.
- R8: `ren_stall` is 1 while the history queue holds HQ_DEPTH instructions, even when free tags remain.
- R9: Recovery to kept sequence number k leaves the table as it was just after instruction k. A restored mapping's ready bit also reflects any broadcasts of that tag made while the younger instructions were in flight.
- R10: Recovery unwinds one queued instruction per cycle, youngest first, and returns each unwound destination tag to the free FIFO in that order. `ren_stall` stays 1 from the request cycle until the unwind ends. With N younger entries, it stays 1 for N+1 cycles after the request edge.
- R11: `ren_seq` gives the history-queue slot the current instruction would take. It advances by one for each accepted instruction, with or without a destination, wraps modulo HQ_DEPTH, and moves back to k+1 after a recovery to k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_valid | input | 1 | Instruction presented for rename |
| ren_src_a | input | ARCH_W | First source register number |
| ren_src_b | input | ARCH_W | Second source register number |
| ren_has_dst | input | 1 | Instruction writes a destination |
| ren_dst | input | ARCH_W | Destination register number |
| ren_stall | output | 1 | Rename cannot accept this cycle |
| src_a_tag | output | TAG_W | Physical tag of first source |
| src_a_rdy | output | 1 | First source value available |
| src_b_tag | output | TAG_W | Physical tag of second source |
| src_b_rdy | output | 1 | Second source value available |
| dst_tag | output | TAG_W | Tag allocated to the destination (free FIFO head) |
| ren_seq | output | HQ_AW | Sequence number of the instruction being renamed |
| res_valid | input | 1 | Result broadcast valid |
| res_tag | input | TAG_W | Tag of the broadcast result |
| grad_valid | input | 1 | Oldest instruction graduates (not while a recovery runs) |
| rec_valid | input | 1 | Start a recovery |
| rec_keep_seq | input | HQ_AW | Sequence number of the last instruction to keep |

## Verification
The bench sets up a source whose tag is broadcast in the same cycle it is read. A design without the bypass would report that source busy for one cycle, and an issue slot would be lost. It also makes an instruction read a register and overwrite it, which catches a design that lets sources see their own new tag. A recovery runs across a mapping whose displaced tag was broadcast after it was saved. A design that did not snoop the history queue would restore that register as busy forever. A design that unwound in the wrong order, or forgot to free the unwound tags, shows up in the free-tag hand-out order afterwards. The free FIFO is drained until it is empty, and the history queue is filled with free tags still left, to show that each limit stalls rename on its own.

// File: rtl/rename_pkg.sv
package rename_pkg;
  parameter int ARCH_W   = 3;
  parameter int TAG_W    = 4;
  parameter int HQ_AW    = 4;
  parameter int NUM_ARCH = 1 << ARCH_W;
  parameter int NUM_PHYS = 1 << TAG_W;

  typedef struct packed {
    logic              has_dst;
    logic [ARCH_W-1:0] dst;
    logic [TAG_W-1:0]  old_tag;
    logic              old_rdy;
    logic [TAG_W-1:0]  new_tag;
  } hist_ent_t;
endpackage

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int TAG_W    = 4,
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pop,
  input  logic             push,
  input  logic [TAG_W-1:0] push_tag,
  output logic [TAG_W-1:0] head_tag,
  output logic             empty
);
  localparam int AW    = TAG_W;
  localparam int DEPTH = 1 << AW;
  localparam int NFREE = NUM_PHYS - NUM_ARCH;

  logic [TAG_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]    rd_q, rd_n, wr_q, wr_n;
  logic [AW:0]      cnt_q, cnt_n;

  always_comb begin
    rd_n  = rd_q;
    wr_n  = wr_q;
    cnt_n = cnt_q;
    if (pop)  rd_n = rd_q + 1'b1;
    if (push) wr_n = wr_q + 1'b1;
    cnt_n = cnt_q + (AW+1)'(push) - (AW+1)'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        mem_q[i] <= (i < NFREE) ? TAG_W'(NUM_ARCH + i) : '0;
      rd_q  <= '0;
      wr_q  <= AW'(NFREE);
      cnt_q <= (AW+1)'(NFREE);
    end else begin
      if (push) mem_q[wr_q] <= push_tag;
      rd_q  <= rd_n;
      wr_q  <= wr_n;
      cnt_q <= cnt_n;
    end
  end

  assign head_tag = mem_q[rd_q];
  assign empty    = (cnt_q == '0);

  p_no_pop_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> cnt_q != '0);
  p_no_push_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> cnt_q < (AW+1)'(DEPTH));
endmodule

// File: rtl/rn_hist_queue.sv
module rn_hist_queue
  import rename_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  hist_ent_t        push_ent,
  input  logic             pop_head,
  input  logic             pop_tail,
  input  logic             bc_valid,
  input  logic [TAG_W-1:0] bc_tag,
  output logic             head_has_dst,
  output logic [TAG_W-1:0] head_old_tag,
  output hist_ent_t        tail_ent,
  output logic [AW-1:0]    tail_ptr,
  output logic             full,
  output logic             empty
);
  localparam int DEPTH = 1 << AW;

  hist_ent_t     mem_q [DEPTH];
  hist_ent_t     mem_n [DEPTH];
  logic [AW-1:0] hd_q, hd_n, tl_q, tl_n, tl_m1;
  logic [AW:0]   cnt_q, cnt_n;

  assign tl_m1 = tl_q - 1'b1;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      mem_n[i] = mem_q[i];
      if (bc_valid && mem_q[i].old_tag == bc_tag) mem_n[i].old_rdy = 1'b1;
    end
    if (push) mem_n[tl_q] = push_ent;
    hd_n  = pop_head ? hd_q + 1'b1 : hd_q;
    tl_n  = push ? tl_q + 1'b1 : (pop_tail ? tl_m1 : tl_q);
    cnt_n = cnt_q + (AW+1)'(push) - (AW+1)'(pop_head) - (AW+1)'(pop_tail);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      hd_q  <= '0;
      tl_q  <= '0;
      cnt_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_n[i];
      hd_q  <= hd_n;
      tl_q  <= tl_n;
      cnt_q <= cnt_n;
    end
  end

  assign head_has_dst = mem_q[hd_q].has_dst;
  assign head_old_tag = mem_q[hd_q].old_tag;
  assign tail_ent     = mem_q[tl_m1];
  assign tail_ptr     = tl_q;
  assign full         = (cnt_q == (AW+1)'(DEPTH));
  assign empty        = (cnt_q == '0);

  p_no_push_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> cnt_q < (AW+1)'(DEPTH));
  p_tail_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> tl_q == $past(tl_q) + 1'b1);
  p_no_pop_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_head || pop_tail) |-> cnt_q != '0);
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int ARCH_W = 3,
  parameter int TAG_W  = 4,
  parameter int NRD    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ARCH_W-1:0] rd_arch [NRD],
  output logic [TAG_W-1:0]  rd_tag  [NRD],
  output logic              rd_rdy  [NRD],
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic              wr_en,
  input  logic [ARCH_W-1:0] wr_arch,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              wr_rdy
);
  localparam int NUM_ARCH = 1 << ARCH_W;

  logic [TAG_W-1:0]    tag_q [NUM_ARCH];
  logic [TAG_W-1:0]    tag_n [NUM_ARCH];
  logic [NUM_ARCH-1:0] rdy_q, rdy_n;

  always_comb begin
    rdy_n = rdy_q;
    for (int i = 0; i < NUM_ARCH; i++) begin
      tag_n[i] = tag_q[i];
      if (bc_valid && tag_q[i] == bc_tag) rdy_n[i] = 1'b1;
    end
    if (wr_en) begin
      tag_n[wr_arch] = wr_tag;
      rdy_n[wr_arch] = wr_rdy;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ARCH; i++) tag_q[i] <= TAG_W'(i);
      rdy_q <= '1;
    end else begin
      for (int i = 0; i < NUM_ARCH; i++) tag_q[i] <= tag_n[i];
      rdy_q <= rdy_n;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_tag[g] = tag_q[rd_arch[g]];
    assign rd_rdy[g] = rdy_q[rd_arch[g]] | (bc_valid && tag_q[rd_arch[g]] == bc_tag);
  end

  p_alloc_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_rdy) |=> !rdy_q[$past(wr_arch)]);
endmodule

// File: rtl/reg_rename_map.sv
module reg_rename_map
  import rename_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ren_valid,
  input  logic [ARCH_W-1:0] ren_src_a,
  input  logic [ARCH_W-1:0] ren_src_b,
  input  logic              ren_has_dst,
  input  logic [ARCH_W-1:0] ren_dst,
  output logic              ren_stall,
  output logic [TAG_W-1:0]  src_a_tag,
  output logic              src_a_rdy,
  output logic [TAG_W-1:0]  src_b_tag,
  output logic              src_b_rdy,
  output logic [TAG_W-1:0]  dst_tag,
  output logic [HQ_AW-1:0]  ren_seq,
  input  logic              res_valid,
  input  logic [TAG_W-1:0]  res_tag,
  input  logic              grad_valid,
  input  logic              rec_valid,
  input  logic [HQ_AW-1:0]  rec_keep_seq
);
  localparam int NRD = 3;

  logic [ARCH_W-1:0] rd_arch [NRD];
  logic [TAG_W-1:0]  rd_tag  [NRD];
  logic              rd_rdy  [NRD];

  logic              fl_empty, fl_pop, fl_push;
  logic [TAG_W-1:0]  fl_head, fl_push_tag;
  logic              q_full, q_empty, q_push, q_pop_head, q_pop_tail;
  logic              q_head_has_dst;
  logic [TAG_W-1:0]  q_head_old_tag;
  hist_ent_t         q_tail_ent, q_push_ent;
  logic [HQ_AW-1:0]  q_tail_ptr;

  logic              rec_act_q, rec_act_n;
  logic [HQ_AW-1:0]  keep_q, keep_n;
  logic              unwind, fire, alloc;
  logic              wr_en, wr_rdy;
  logic [ARCH_W-1:0] wr_arch;
  logic [TAG_W-1:0]  wr_tag;

  assign rd_arch[0] = ren_src_a;
  assign rd_arch[1] = ren_src_b;
  assign rd_arch[2] = ren_dst;

  assign unwind     = rec_act_q && (q_tail_ptr - 1'b1) != keep_q;
  assign ren_stall  = rec_act_q | rec_valid | fl_empty | q_full;
  assign fire       = ren_valid & ~ren_stall;
  assign alloc      = fire & ren_has_dst;
  assign q_push     = fire;
  assign q_pop_tail = unwind;
  assign q_pop_head = grad_valid & ~q_empty & ~rec_act_q;
  assign fl_pop     = alloc;

  assign q_push_ent = '{has_dst: ren_has_dst, dst: ren_dst, old_tag: rd_tag[2],
                        old_rdy: rd_rdy[2], new_tag: fl_head};

  always_comb begin
    fl_push     = 1'b0;
    fl_push_tag = q_head_old_tag;
    wr_en       = alloc;
    wr_arch     = ren_dst;
    wr_tag      = fl_head;
    wr_rdy      = 1'b0;
    if (unwind && q_tail_ent.has_dst) begin
      fl_push     = 1'b1;
      fl_push_tag = q_tail_ent.new_tag;
      wr_en       = 1'b1;
      wr_arch     = q_tail_ent.dst;
      wr_tag      = q_tail_ent.old_tag;
      wr_rdy      = q_tail_ent.old_rdy | (res_valid && res_tag == q_tail_ent.old_tag);
    end else if (q_pop_head && q_head_has_dst) begin
      fl_push = 1'b1;
    end
  end

  always_comb begin
    rec_act_n = rec_act_q;
    keep_n    = keep_q;
    if (rec_valid && !rec_act_q) begin
      rec_act_n = 1'b1;
      keep_n    = rec_keep_seq;
    end else if (rec_act_q && !unwind) begin
      rec_act_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_act_q <= 1'b0;
      keep_q    <= '0;
    end else begin
      rec_act_q <= rec_act_n;
      keep_q    <= keep_n;
    end
  end

  rn_map_table #(.ARCH_W(ARCH_W), .TAG_W(TAG_W), .NRD(NRD)) u_map (
    .clk(clk), .rst_n(rst_n), .rd_arch(rd_arch), .rd_tag(rd_tag), .rd_rdy(rd_rdy),
    .bc_valid(res_valid), .bc_tag(res_tag), .wr_en(wr_en), .wr_arch(wr_arch),
    .wr_tag(wr_tag), .wr_rdy(wr_rdy));

  rn_free_list #(.TAG_W(TAG_W), .NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_free (
    .clk(clk), .rst_n(rst_n), .pop(fl_pop), .push(fl_push), .push_tag(fl_push_tag),
    .head_tag(fl_head), .empty(fl_empty));

  rn_hist_queue #(.AW(HQ_AW)) u_hist (
    .clk(clk), .rst_n(rst_n), .push(q_push), .push_ent(q_push_ent),
    .pop_head(q_pop_head), .pop_tail(q_pop_tail), .bc_valid(res_valid), .bc_tag(res_tag),
    .head_has_dst(q_head_has_dst), .head_old_tag(q_head_old_tag), .tail_ent(q_tail_ent),
    .tail_ptr(q_tail_ptr), .full(q_full), .empty(q_empty));

  assign src_a_tag = rd_tag[0];
  assign src_a_rdy = rd_rdy[0];
  assign src_b_tag = rd_tag[1];
  assign src_b_rdy = rd_rdy[1];
  assign dst_tag   = fl_head;
  assign ren_seq   = q_tail_ptr;

  p_grad_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rec_act_q |-> !grad_valid);
  p_rec_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_act_q) |=> ren_stall);
endmodule

// File: tb/sim_reg_rename_map.sv
module sim_reg_rename_map;
  import rename_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              ren_valid, ren_has_dst, res_valid, grad_valid, rec_valid;
  logic [ARCH_W-1:0] ren_src_a, ren_src_b, ren_dst;
  logic [TAG_W-1:0]  res_tag;
  logic [HQ_AW-1:0]  rec_keep_seq;
  logic              ren_stall, src_a_rdy, src_b_rdy;
  logic [TAG_W-1:0]  src_a_tag, src_b_tag, dst_tag;
  logic [HQ_AW-1:0]  ren_seq;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  reg_rename_map u0 (.*);

  typedef struct packed {
    logic       v;
    logic [2:0] a, b;
    logic       hd;
    logic [2:0] d;
    logic       bv;
    logic [3:0] bt;
    logic [3:0] ea;
    logic       ear;
    logic [3:0] eb;
    logic       ebr;
    logic [3:0] ed;
    logic       es;
    logic [3:0] eq;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b0,3'd7,3'd0,1'b0,3'd0,1'b0,4'd0, 4'd7,1'b1, 4'd0,1'b1, 4'd8,1'b0,4'd0},
    '{1'b1,3'd1,3'd2,1'b1,3'd3,1'b0,4'd0, 4'd1,1'b1, 4'd2,1'b1, 4'd8,1'b0,4'd0},
    '{1'b1,3'd3,3'd3,1'b1,3'd3,1'b0,4'd0, 4'd8,1'b0, 4'd8,1'b0, 4'd9,1'b0,4'd1},
    '{1'b1,3'd3,3'd0,1'b1,3'd5,1'b1,4'd9, 4'd9,1'b1, 4'd0,1'b1, 4'd10,1'b0,4'd2},
    '{1'b1,3'd3,3'd5,1'b0,3'd0,1'b0,4'd0, 4'd9,1'b1, 4'd10,1'b0,4'd11,1'b0,4'd3},
    '{1'b0,3'd5,3'd1,1'b0,3'd0,1'b1,4'd10,4'd10,1'b1,4'd1,1'b1, 4'd11,1'b0,4'd4},
    '{1'b1,3'd5,3'd3,1'b1,3'd5,1'b0,4'd0, 4'd10,1'b1,4'd9,1'b1, 4'd11,1'b0,4'd4},
    '{1'b0,3'd3,3'd5,1'b0,3'd0,1'b1,4'd8, 4'd9,1'b1, 4'd11,1'b0,4'd12,1'b0,4'd5}
  };

  localparam int REFILL [7] = '{12, 13, 14, 15, 11, 10, 9};

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    ren_valid = 0; ren_has_dst = 0; ren_src_a = 0; ren_src_b = 0; ren_dst = 0;
    res_valid = 0; res_tag = 0; grad_valid = 0; rec_valid = 0; rec_keep_seq = 0;
  endtask

  task automatic ren(input int a, input int b, input bit hd, input int d);
    idle();
    ren_valid = 1; ren_src_a = ARCH_W'(a); ren_src_b = ARCH_W'(b);
    ren_has_dst = hd; ren_dst = ARCH_W'(d);
  endtask

  initial begin
    #(20 * 5000);
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int n_st;
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 R2 R3 R4 R5 R11: table walk
    foreach (VEC[k]) begin
      @(negedge clk);
      idle();
      ren_valid = VEC[k].v; ren_src_a = VEC[k].a; ren_src_b = VEC[k].b;
      ren_has_dst = VEC[k].hd; ren_dst = VEC[k].d;
      res_valid = VEC[k].bv; res_tag = VEC[k].bt;
      #2;
      check($sformatf("R2 vec%0d src_a_tag", k), src_a_tag, VEC[k].ea);
      check($sformatf("R5 vec%0d src_a_rdy", k), src_a_rdy, VEC[k].ear);
      check($sformatf("R2 vec%0d src_b_tag", k), src_b_tag, VEC[k].eb);
      check($sformatf("R4 vec%0d src_b_rdy", k), src_b_rdy, VEC[k].ebr);
      check($sformatf("R3 vec%0d dst_tag", k), dst_tag, VEC[k].ed);
      check($sformatf("R7 vec%0d stall", k), ren_stall, VEC[k].es);
      check($sformatf("R11 vec%0d seq", k), ren_seq, VEC[k].eq);
    end

    // R10 R9: recover keeping seq 0, four younger entries
    @(negedge clk);
    idle(); rec_valid = 1; rec_keep_seq = 0;
    #2 check("R10 stall on request", ren_stall, 1);
    n_st = 0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      idle();
      #2;
      if (ren_stall) n_st++;
    end
    check("R10 stall cycles", n_st, 5);
    @(negedge clk);
    idle(); ren_src_a = 3; ren_src_b = 5;
    #2;
    check("R9 arch3 tag", src_a_tag, 8);
    check("R9 arch3 ready snooped", src_a_rdy, 1);
    check("R9 arch5 tag", src_b_tag, 5);
    check("R9 arch5 ready", src_b_rdy, 1);
    check("R11 seq after recovery", ren_seq, 1);

    // R10 R6: returned tags come out in unwind order
    foreach (REFILL[k]) begin
      @(negedge clk);
      ren(6, 6, 1, 6);
      #2;
      check("R10 refill tag", dst_tag, REFILL[k]);
      check("R7 no stall", ren_stall, 0);
    end
    // R7: free FIFO empty
    @(negedge clk);
    ren(6, 0, 1, 6);
    #2;
    check("R7 stall when empty", ren_stall, 1);
    check("R7 mapping kept", src_a_tag, 9);
    @(negedge clk);
    idle(); ren_src_a = 6;
    #2 check("R7 no write while stalled", src_a_tag, 9);

    // R6: graduate seq0 (displaced tag 3)
    @(negedge clk);
    idle(); grad_valid = 1;
    @(negedge clk);
    ren(0, 0, 1, 7);
    #2;
    check("R6 stall cleared", ren_stall, 0);
    check("R6 freed tag reused", dst_tag, 3);
    @(negedge clk);
    idle();
    #2 check("R7 empty again", ren_stall, 1);

    // R8: queue full with a free tag left
    @(negedge clk);
    idle(); grad_valid = 1;
    for (int k = 0; k < 9; k++) begin
      @(negedge clk);
      ren(1, 2, 0, 0);
      #2 check("R8 accepting", ren_stall, 0);
    end
    @(negedge clk);
    ren(1, 2, 1, 4);
    #2;
    check("R8 stall when queue full", ren_stall, 1);
    check("R8 free tag still there", dst_tag, 6);
    check("R11 seq wrapped", ren_seq, 2);

    @(negedge clk);
    idle();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule